// File: doc/BRIEF.md
# Prioritized Exception Arbiter with Vector Address Generation

This block picks the exception that a small microcontroller core should service next, and produces the memory address of that exception's handler pointer. It watches a soft-reset request, a non-maskable interrupt, a hard-fault request, five system exception lines, a software-pended context-switch request and `N_IRQ` external interrupt lines. Each source whose priority can be programmed has a priority register. The winner's number and priority are reported together with a flag that says whether it should preempt the code that is running now.

The handler pointer is read from a table of 32-bit words. The table's base address is held in a writable register. After a hardware reset or a soft-reset request, the block runs a short boot sequence before it arbitrates at all. It first offers table word 0, which holds the initial stack pointer. It then offers word 1, which holds the reset entry point. The core moves the sequence forward by acknowledging each fetch. A simple write port loads the configuration.

Top module: `exc_arbiter`

## Requirements
- R1: While `rst_n` is low, the outputs show the stack-pointer fetch: `exc_valid`=1, `exc_num`=0, `exc_prio`=-3, `vec_addr`=0 and `preempt`=1. The table base and all priorities reset to 0, and the mask and the context-switch pend bit reset to 0.
- R2: Fixed priorities apply. Both boot fetches report -3, exception 2 (non-maskable, from `nmi_req`) reports -2, and exception 3 (hard fault, from `fault_req`) reports -1. These win over every programmable source, whose priorities run from 0 to 2^PRIO_W-1.
- R3: The global mask blocks every programmable source. It never blocks exceptions 2 and 3.
- R4: Among pending sources, the lowest priority value wins. On equal priority, the lower exception number wins.
- R5: Boot sequence. A cycle with `exc_ack`=1 moves the output from word 0 to word 1, and a second such cycle moves it into normal arbitration. `rst_req`=1 restarts the sequence at word 0 and takes precedence over `exc_ack`.
- R6: `preempt` is 1 only when `exc_valid` is 1 and `exc_prio` is strictly less than the signed input `cur_prio`.
- R7: `vec_addr` = table base + 4 × `exc_num`. The system lines `sys_req[0..4]` map to exceptions 4, 5, 6, 11 and 15. External line i maps to exception 16+i. When nothing is pending, `exc_valid`=0, `exc_num`=0, `exc_prio`=0 and `vec_addr` = base.
- R8: A write to address 0 loads the table base from `wr_data`, with bits 6:0 forced to zero.
- R9: A write to address 1 does three things. Bit 0 sets the pend bit of exception 14, bit 1 clears it (bit 0 wins if both are 1), and bit 2 loads the global mask. The pend bit is also cleared by an `exc_ack` cycle while exception 14 is the reported winner in normal arbitration.
- R10: A write to address n loads `wr_data[PRIO_W-1:0]` as the priority of exception n when n is programmable (4, 5, 6, 11, 14, 15, or 16 and above). Writes to any other number have no effect.
- R11: Outputs are registered. After each rising edge, they reflect the register contents as updated at that edge, combined with the request lines and `cur_prio` sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_req | input | 1 | Soft reset request, restarts boot fetches |
| nmi_req | input | 1 | Non-maskable interrupt request (exception 2) |
| fault_req | input | 1 | Hard fault request (exception 3) |
| sys_req | input | 5 | System exception requests (exceptions 4, 5, 6, 11, 15) |
| irq_req | input | N_IRQ | External interrupt requests (exceptions 16 and up) |
| cur_prio | input | PRIO_W+2 | Signed current execution priority |
| exc_ack | input | 1 | Core accepted the reported fetch or exception |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 8 | Configuration write address |
| wr_data | input | 32 | Configuration write data |
| exc_valid | output | 1 | An exception or boot fetch is reported |
| exc_num | output | $clog2(16+N_IRQ) | Selected exception number (0 = stack pointer word) |
| exc_prio | output | PRIO_W+2 | Signed priority of the selection |
| preempt | output | 1 | Selection should preempt current execution |
| vec_addr | output | 32 | Address of the table word to fetch |

## Verification
Directed patterns come first. A single source on its own checks the number mapping and the vector address. Several external lines with distinct priorities check that the lowest value wins. Two lines with the same priority expose an arbiter that breaks ties in the wrong direction. The non-maskable and fault requests are mixed with programmable ones, both with the mask off and with it on, to separate fixed-priority handling from masking. A sweep of `cur_prio` around the winner's priority shows whether the preempt compare is strict. Random traffic follows, mixing writes, acknowledges and soft resets. A behavioural model checks every cycle, which catches off-by-one-cycle errors in the boot sequence and in the pend-bit clearing.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;

    localparam int ADDR_W    = 32;
    localparam int EXC_NMI   = 2;
    localparam int EXC_HARD  = 3;
    localparam int EXC_CTXSW = 14;
    localparam int EXC_EXT0  = 16;
    localparam int N_SYS     = 5;
    localparam int BASE_ALIGN = 7;

    localparam logic [7:0] WA_BASE = 8'd0;
    localparam logic [7:0] WA_CTRL = 8'd1;

    typedef enum logic [1:0] {
        BOOT_SP = 2'd0,
        BOOT_PC = 2'd1,
        ARB_RUN = 2'd2
    } boot_st_e;

    // Exception numbers whose priority is programmable
    function automatic logic is_cfg(input int n);
        return (n == 4) || (n == 5) || (n == 6) || (n == 11) ||
               (n == EXC_CTXSW) || (n == 15) || (n >= EXC_EXT0);
    endfunction

    // Position of a hardware system line within sys_req
    function automatic int sys_index(input int n);
        case (n)
            4:       return 0;
            5:       return 1;
            6:       return 2;
            11:      return 3;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/exc_cfg_regs.sv
module exc_cfg_regs
    import exc_arb_pkg::*;
#(
    parameter int NUM_EXC = 32,
    parameter int PRIO_W  = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [7:0]                       wr_addr,
    input  logic [31:0]                      wr_data,
    input  logic                             ctx_ack_clr,
    output logic [NUM_EXC-1:0][PRIO_W-1:0]   prio_d_o,
    output logic [ADDR_W-1:0]                base_d_o,
    output logic                             mask_d_o,
    output logic                             pend_d_o
);

    typedef struct packed {
        logic [NUM_EXC-1:0][PRIO_W-1:0] prio;
        logic [ADDR_W-1:0]              base;
        logic                           mask;
        logic                           pend;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (ctx_ack_clr) begin
            r_d.pend = 1'b0;
        end
        if (wr_en) begin
            if (wr_addr == WA_BASE) begin
                r_d.base = {wr_data[ADDR_W-1:BASE_ALIGN], {BASE_ALIGN{1'b0}}};
            end
            if (wr_addr == WA_CTRL) begin
                if (wr_data[1]) r_d.pend = 1'b0;
                if (wr_data[0]) r_d.pend = 1'b1;
                r_d.mask = wr_data[2];
            end
            for (int n = 0; n < NUM_EXC; n++) begin
                if (is_cfg(n) && (wr_addr == 8'(n))) begin
                    r_d.prio[n] = wr_data[PRIO_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign prio_d_o = r_d.prio;
    assign base_d_o = r_d.base;
    assign mask_d_o = r_d.mask;
    assign pend_d_o = r_d.pend;

    assert_base_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.base[BASE_ALIGN-1:0] == '0);

    assert_pend_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == WA_CTRL && wr_data[0]) |=> r_q.pend);

endmodule

// File: rtl/exc_boot_seq.sv
module exc_boot_seq
    import exc_arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rst_req,
    input  logic     advance,
    output boot_st_e st_d_o,
    output boot_st_e st_q_o
);

    boot_st_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst_req) begin
            st_d = BOOT_SP;
        end else if (advance) begin
            case (st_q)
                BOOT_SP: st_d = BOOT_PC;
                BOOT_PC: st_d = ARB_RUN;
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= BOOT_SP;
        end else begin
            st_q <= st_d;
        end
    end

    assign st_d_o = st_d;
    assign st_q_o = st_q;

    assert_boot_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BOOT_SP && advance && !rst_req) |=> (st_q == BOOT_PC));

    assert_run_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ARB_RUN && !rst_req) |=> (st_q == ARB_RUN));

endmodule

// File: rtl/exc_select.sv
module exc_select #(
    parameter int NUM_EXC = 32,
    parameter int PW      = 5,
    parameter int NUM_W   = 5
) (
    input  logic [NUM_EXC-1:0]         req_i,
    input  logic [NUM_EXC-1:0][PW-1:0] prio_i,
    output logic                       found_o,
    output logic [NUM_W-1:0]           num_o,
    output logic [PW-1:0]              prio_o
);

    always_comb begin
        found_o = 1'b0;
        num_o   = '0;
        prio_o  = '0;
        // ascending scan with strict compare: ties keep the lower number
        for (int n = 0; n < NUM_EXC; n++) begin
            if (req_i[n] && (!found_o || ($signed(prio_i[n]) < $signed(prio_o)))) begin
                found_o = 1'b1;
                num_o   = NUM_W'(n);
                prio_o  = prio_i[n];
            end
        end
    end

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_arb_pkg::*;
#(
    parameter int N_IRQ  = 16,
    parameter int PRIO_W = 3,
    localparam int NUM_EXC = EXC_EXT0 + N_IRQ,
    localparam int NUM_W   = $clog2(NUM_EXC),
    localparam int PW      = PRIO_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_req,
    input  logic              nmi_req,
    input  logic              fault_req,
    input  logic [N_SYS-1:0]  sys_req,
    input  logic [N_IRQ-1:0]  irq_req,
    input  logic [PW-1:0]     cur_prio,
    input  logic              exc_ack,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [31:0]       wr_data,
    output logic              exc_valid,
    output logic [NUM_W-1:0]  exc_num,
    output logic [PW-1:0]     exc_prio,
    output logic              preempt,
    output logic [ADDR_W-1:0] vec_addr
);

    typedef struct packed {
        logic              valid;
        logic [NUM_W-1:0]  num;
        logic [PW-1:0]     prio;
        logic              preempt;
        logic [ADDR_W-1:0] vec;
    } out_t;

    out_t out_d, out_q;

    logic [NUM_EXC-1:0][PRIO_W-1:0] prio_d;
    logic [ADDR_W-1:0]              base_d;
    logic                           mask_d;
    logic                           pend_d;
    logic                           ctx_ack_clr;
    boot_st_e                       st_d, st_q;

    logic [NUM_EXC-1:0]             req;
    logic [NUM_EXC-1:0][PW-1:0]     eff;
    logic                           win_found;
    logic [NUM_W-1:0]               win_num;
    logic [PW-1:0]                  win_prio;

    assign ctx_ack_clr = exc_ack && out_q.valid && (st_q == ARB_RUN) &&
                         (out_q.num == NUM_W'(EXC_CTXSW));

    exc_cfg_regs #(.NUM_EXC(NUM_EXC), .PRIO_W(PRIO_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .ctx_ack_clr (ctx_ack_clr),
        .prio_d_o    (prio_d),
        .base_d_o    (base_d),
        .mask_d_o    (mask_d),
        .pend_d_o    (pend_d)
    );

    exc_boot_seq u_boot (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_req (rst_req),
        .advance (exc_ack && out_q.valid),
        .st_d_o  (st_d),
        .st_q_o  (st_q)
    );

    // Request and effective priority per exception number
    for (genvar n = 0; n < NUM_EXC; n++) begin : g_src
        if (n == EXC_NMI) begin : g_nmi
            assign req[n] = nmi_req;
            assign eff[n] = PW'(-2);
        end else if (n == EXC_HARD) begin : g_hard
            assign req[n] = fault_req;
            assign eff[n] = PW'(-1);
        end else if (n >= EXC_EXT0) begin : g_ext
            assign req[n] = irq_req[n-EXC_EXT0] & ~mask_d;
            assign eff[n] = {2'b00, prio_d[n]};
        end else if (n == EXC_CTXSW) begin : g_ctx
            assign req[n] = pend_d & ~mask_d;
            assign eff[n] = {2'b00, prio_d[n]};
        end else if (is_cfg(n)) begin : g_sys
            assign req[n] = sys_req[sys_index(n)] & ~mask_d;
            assign eff[n] = {2'b00, prio_d[n]};
        end else begin : g_none
            assign req[n] = 1'b0;
            assign eff[n] = '0;
        end
    end

    exc_select #(.NUM_EXC(NUM_EXC), .PW(PW), .NUM_W(NUM_W)) u_sel (
        .req_i   (req),
        .prio_i  (eff),
        .found_o (win_found),
        .num_o   (win_num),
        .prio_o  (win_prio)
    );

    always_comb begin
        out_d = '0;
        if (st_d != ARB_RUN) begin
            out_d.valid = 1'b1;
            out_d.num   = (st_d == BOOT_PC) ? NUM_W'(1) : '0;
            out_d.prio  = PW'(-3);
        end else begin
            out_d.valid = win_found;
            out_d.num   = win_num;
            out_d.prio  = win_prio;
        end
        out_d.vec     = base_d + ADDR_W'({out_d.num, 2'b00});
        out_d.preempt = out_d.valid && ($signed(out_d.prio) < $signed(cur_prio));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q         <= '0;
            out_q.valid   <= 1'b1;
            out_q.prio    <= PW'(-3);
            out_q.preempt <= 1'b1;
        end else begin
            out_q <= out_d;
        end
    end

    assign exc_valid = out_q.valid;
    assign exc_num   = out_q.num;
    assign exc_prio  = out_q.prio;
    assign preempt   = out_q.preempt;
    assign vec_addr  = out_q.vec;

    assert_preempt_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        preempt |-> exc_valid);

    assert_boot_prio_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ARB_RUN) |-> (exc_valid && $signed(exc_prio) == -3));

    assert_nmi_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && !rst_req && st_d == ARB_RUN) |=>
            (exc_valid && exc_num == NUM_W'(EXC_NMI) && $signed(exc_prio) == -2));

    assert_fault_prio_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && st_q == ARB_RUN && exc_num == NUM_W'(EXC_HARD)) |->
            ($signed(exc_prio) == -1));

endmodule

// File: tb/tb_exc_arbiter.sv
`timescale 1ns/1ps
module tb_exc_arbiter;

    localparam int N_IRQ  = 16;
    localparam int PRIO_W = 3;
    localparam int NEXC   = 16 + N_IRQ;
    localparam int NUM_W  = $clog2(NEXC);
    localparam int PW     = PRIO_W + 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              rst_req = 0, nmi_req = 0, fault_req = 0, exc_ack = 0, wr_en = 0;
    logic [4:0]        sys_req = '0;
    logic [N_IRQ-1:0]  irq_req = '0;
    logic [PW-1:0]     cur_prio = '0;
    logic [7:0]        wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic              exc_valid, preempt;
    logic [NUM_W-1:0]  exc_num;
    logic [PW-1:0]     exc_prio;
    logic [31:0]       vec_addr;

    exc_arbiter #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) dut (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .nmi_req(nmi_req),
        .fault_req(fault_req), .sys_req(sys_req), .irq_req(irq_req),
        .cur_prio(cur_prio), .exc_ack(exc_ack), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .exc_valid(exc_valid),
        .exc_num(exc_num), .exc_prio(exc_prio), .preempt(preempt),
        .vec_addr(vec_addr)
    );

    always #2 clk = ~clk;   // 250 MHz

    int    n_chk = 0;
    int    n_err = 0;
    string tag = "R1";

    // ---------------- behavioural reference model ----------------
    int         m_prio [NEXC];
    logic [31:0] m_base;
    bit         m_pend, m_mask;
    int         m_state;        // 0 stack word, 1 entry word, 2 running
    bit         e_valid, e_pre;
    int         e_num, e_prio;
    logic [31:0] e_vec;

    function automatic bit m_cfg(int n);
        return (n inside {4, 5, 6, 11, 14, 15}) || (n >= 16 && n < NEXC);
    endfunction

    function automatic bit m_req(int n);
        if (n == 2) return nmi_req;
        if (n == 3) return fault_req;
        if (m_mask) return 0;
        if (n >= 16) return irq_req[n-16];
        case (n)
            4:  return sys_req[0];
            5:  return sys_req[1];
            6:  return sys_req[2];
            11: return sys_req[3];
            15: return sys_req[4];
            14: return m_pend;
            default: return 0;
        endcase
    endfunction

    function automatic int m_eff(int n);
        if (n == 2) return -2;
        if (n == 3) return -1;
        return m_prio[n];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (m_prio[i]) m_prio[i] = 0;
            m_base = 0; m_pend = 0; m_mask = 0; m_state = 0;
            e_valid = 1; e_num = 0; e_prio = -3; e_vec = 0; e_pre = 1;
        end else begin
            bit was_run;
            was_run = (m_state == 2);
            if (exc_ack && was_run && e_valid && e_num == 14) m_pend = 0;
            if (rst_req) m_state = 0;
            else if (exc_ack && e_valid && m_state < 2) m_state++;
            if (wr_en) begin
                if (wr_addr == 0) m_base = wr_data & 32'hFFFF_FF80;
                if (wr_addr == 1) begin
                    if (wr_data[1]) m_pend = 0;
                    if (wr_data[0]) m_pend = 1;
                    m_mask = wr_data[2];
                end
                if (m_cfg(int'(wr_addr))) m_prio[wr_addr] = int'(wr_data[PRIO_W-1:0]);
            end
            if (m_state < 2) begin
                e_valid = 1; e_num = m_state; e_prio = -3;
            end else begin
                e_valid = 0; e_num = 0; e_prio = 0;
                for (int n = 0; n < NEXC; n++) begin
                    if (m_req(n) && (!e_valid || m_eff(n) < e_prio)) begin
                        e_valid = 1; e_num = n; e_prio = m_eff(n);
                    end
                end
            end
            e_vec = m_base + 32'(4 * e_num);
            e_pre = e_valid && (e_prio < int'($signed(cur_prio)));
        end
    end

    task automatic chk(string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        chk("exc_valid", exc_valid, e_valid);
        chk("exc_num", exc_num, e_num);
        chk("exc_prio", $signed(exc_prio), e_prio);
        chk("preempt", preempt, e_pre);
        chk("vec_addr", vec_addr, e_vec);
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(int a, logic [31:0] d);
        wr_en = 1; wr_addr = 8'(a); wr_data = d;
        cyc(1);
        wr_en = 0;
    endtask

    task automatic ack1();
        exc_ack = 1; cyc(1); exc_ack = 0;
    endtask

    initial begin
        #(4 * 150000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1;
        #1 rst_n = 0;
        tag = "R1";
        #9;                       // negedges during reset compare reset state
        @(posedge clk); #1 rst_n = 1;
        cyc(3);

        tag = "R5";               // boot fetch sequence
        ack1(); cyc(2); ack1(); cyc(2);

        tag = "R8";
        wr(0, 32'h2000_00D5); cyc(1);

        tag = "R10";
        wr(16, 5); wr(17, 2); wr(18, 2); wr(4, 6); wr(2, 0); wr(7, 1); wr(14, 3);
        cyc(1);

        tag = "R4";
        irq_req[2:0] = 3'b111; cyc(2);
        irq_req[1] = 0; cyc(2);
        irq_req = '0; sys_req[0] = 1; irq_req[0] = 1; cyc(2);
        sys_req = '0; irq_req = '0; cyc(1);

        tag = "R7";
        irq_req[5] = 1; cyc(2);
        irq_req = '0; sys_req[3] = 1; cyc(2); sys_req = '0; cyc(2);

        tag = "R2";
        irq_req[5] = 1; nmi_req = 1; cyc(2);
        nmi_req = 0; fault_req = 1; cyc(2);
        nmi_req = 1; cyc(2);
        nmi_req = 0; fault_req = 0; cyc(1);

        tag = "R3";
        wr(1, 32'h4); irq_req = '1; sys_req = '1; cyc(2);
        nmi_req = 1; cyc(2); nmi_req = 0; fault_req = 1; cyc(2);
        fault_req = 0; wr(1, 32'h0); cyc(2);
        irq_req = '0; sys_req = '0;

        tag = "R6";
        irq_req[1] = 1;
        cur_prio = 5'd2; cyc(2);
        cur_prio = 5'd3; cyc(2);
        irq_req = '0; nmi_req = 1;
        cur_prio = PW'(-2); cyc(2);
        cur_prio = PW'(-1); cyc(2);
        nmi_req = 0; cur_prio = 5'd7; cyc(1);

        tag = "R9";
        wr(1, 32'h1); cyc(2);
        ack1(); cyc(2);
        wr(1, 32'h3); cyc(2);
        wr(1, 32'h2); cyc(2);
        wr(1, 32'h1); irq_req[1] = 1; cyc(2); ack1(); cyc(2);
        irq_req = '0; cyc(2); ack1(); cyc(2);

        tag = "R5";
        irq_req[3] = 1; rst_req = 1; exc_ack = 1; cyc(1);
        rst_req = 0; exc_ack = 0; cyc(2);
        ack1(); cyc(1); ack1(); cyc(2); irq_req = '0;

        tag = "R11";
        for (int i = 0; i < 3000; i++) begin
            nmi_req   = ($urandom_range(0, 15) == 0);
            fault_req = ($urandom_range(0, 11) == 0);
            sys_req   = 5'($urandom);
            irq_req   = N_IRQ'($urandom) & N_IRQ'($urandom);
            cur_prio  = PW'($urandom_range(0, 12)) - PW'(4);
            exc_ack   = ($urandom_range(0, 3) == 0);
            rst_req   = ($urandom_range(0, 99) == 0);
            wr_en     = ($urandom_range(0, 4) == 0);
            wr_addr   = 8'($urandom_range(0, NEXC + 2));
            wr_data   = $urandom;
            if (wr_addr == 1) wr_data[2] = ($urandom_range(0, 3) == 0);
            cyc(1);
        end
        wr_en = 0; exc_ack = 0; rst_req = 0;
        cyc(2);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule